// File: doc/BRIEF.md
# Receive Frame Drain Sequencer

This block empties the receive queue of an Ethernet controller that is reached through a 16-bit register-access port. When the controller's interrupt line is high, the sequencer reads the interrupt status word. If the receive-pending flag is set, it clears the flag and reads how many frames are waiting. It then handles each waiting frame in turn. It reads the frame's status word and its byte count, and judges the frame. A bad frame is released back to the controller. A good frame is pulled across in one bulk read.

The register port carries one transaction at a time. The sequencer holds request, address, write flag and write data until the acknowledge arrives. Bulk data returns as a byte stream. The sequencer drops the header bytes and the alignment padding. It presents the payload with a length tag and a last-byte flag. Three saturating counters record dropped frames, one counter per reason.

Top module: `rx_drain_seq`

## Requirements
- R1: After reset, no register request, no bulk start and no output byte is active, and all three drop counters read zero.
- R2: With the interrupt input high, the block reads address 0x92. Only if bit 13 of that word is set does it write 0x2000 to 0x92 and then read 0x9C. Otherwise it returns to idle without writing.
- R3: For each frame, the block reads the status word at 0x7C and then the byte count at 0x7E. The frame length is bits 11:0 of the byte count, and the upper bits are ignored.
- R4: A frame is accepted only when status bit 15 is set and status bits 0, 1, 2, 4, 10, 11, 12 and 13 are all clear. Other status bits, such as bit 3, do not affect the decision.
- R5: A frame whose status is acceptable but whose length is zero is dropped.
- R6: The padded length is the frame length rounded up to a multiple of 4. A frame whose padded length exceeds 1500 is dropped, so lengths 1497 to 1500 pass and 1501 drops.
- R7: To drop a frame, the block reads 0x82 and writes the value back with bit 0 set, keeping all other bits. It then re-reads 0x82 until bit 0 is 0, and only then moves to the next frame.
- R8: To accept a frame, the block writes 0x4000 to 0x86 and sets bit 3 of 0x82 by read-modify-write. It then pulses bulk_start_o with a byte count of 8 plus the padded length. When the bulk read is complete, it clears bit 3 of 0x82 by read-modify-write.
- R9: Bulk bytes are taken from the cycle after bulk_start_o. The first 8 bytes are discarded. Only the first length bytes of the rest appear on the output. out_last_o marks the final byte, and out_len_o carries the frame length.
- R10: Each drop increments exactly one saturating counter. A bad status counts as a status drop even when the length is also zero. A zero length counts before an oversize length.
- R11: The number of frames handled equals the upper byte of the 0x9C word, and no status is read beyond that count. A count of zero reads no frame. After the last frame, the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 1 | Controller interrupt line |
| reg_req_o | output | 1 | Register transaction request |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | 8 | Register byte address |
| reg_wdata_o | output | 16 | Write data |
| reg_ack_i | input | 1 | Transaction done; read data valid |
| reg_rdata_i | input | 16 | Read data |
| bulk_start_o | output | 1 | One-cycle start of a bulk read |
| bulk_bytes_o | output | LEN_W+1 | Bytes in the bulk read |
| bulk_valid_i | input | 1 | Bulk byte valid |
| bulk_data_i | input | 8 | Bulk byte |
| out_valid_o | output | 1 | Payload byte valid |
| out_data_o | output | 8 | Payload byte |
| out_last_o | output | 1 | Final payload byte of the frame |
| out_len_o | output | LEN_W | Frame length tag |
| drop_status_o | output | CNT_W | Drops caused by status |
| drop_zero_o | output | CNT_W | Drops caused by zero length |
| drop_long_o | output | CNT_W | Drops caused by oversize length |

## Verification
A register transaction ends at the clock edge that sees reg_ack_i. The next request appears in the cycle after that edge. The bench's register model therefore acknowledges on falling edges, and it checks ordering and write values as each transaction completes. A payload byte appears on the output one cycle after its bulk byte is accepted. The scoreboard pops on every falling edge with out_valid_o high, so latency does not need to be modelled. Each drop counter settles two edges after the byte-count read completes. The counters are compared only after the bench has seen every frame finish at the register port.

// File: rtl/rx_drain_pkg.sv
package rx_drain_pkg;
  localparam logic [7:0] A_ISR  = 8'h92;
  localparam logic [7:0] A_FCNT = 8'h9C;
  localparam logic [7:0] A_STAT = 8'h7C;
  localparam logic [7:0] A_BCNT = 8'h7E;
  localparam logic [7:0] A_RPTR = 8'h86;
  localparam logic [7:0] A_QCMD = 8'h82;
  localparam int B_RXIRQ = 13;
  localparam int B_OK    = 15;
  localparam int B_REL   = 0;
  localparam int B_DMA   = 3;
  localparam int B_AINC  = 14;
  localparam logic [15:0] ERR_MASK = 16'h3C17;

  typedef enum logic [3:0] {
    S_IDLE, S_ISR, S_ACK, S_CNT, S_STAT, S_LEN, S_JUDGE, S_PTR,
    S_CRD, S_CWR, S_POLL, S_BULK, S_BWAIT, S_NEXT
  } state_e;

  typedef enum logic [1:0] {OP_REL, OP_DMA_ON, OP_DMA_OFF} cmd_op_e;

  localparam int N_REASON = 3;  // 0 status, 1 zero length, 2 oversize
endpackage

// File: rtl/rx_frame_judge.sv
module rx_frame_judge
  import rx_drain_pkg::*;
#(
  parameter int LEN_W    = 12,
  parameter int MAX_XFER = 1500,
  localparam int XW      = LEN_W + 1
) (
  input  logic [15:0]         status_i,
  input  logic [LEN_W-1:0]    len_i,
  output logic [N_REASON-1:0] reason_o,
  output logic [XW-1:0]       pad_o
);
  logic bad, zero, big;

  assign pad_o = ({1'b0, len_i} + XW'(3)) & ~XW'(3);
  assign bad   = !status_i[B_OK] || ((status_i & ERR_MASK) != '0);
  assign zero  = (len_i == '0);
  assign big   = (pad_o > XW'(MAX_XFER));

  always_comb begin
    reason_o = '0;
    if (bad)       reason_o[0] = 1'b1;
    else if (zero) reason_o[1] = 1'b1;
    else if (big)  reason_o[2] = 1'b1;
  end
endmodule

// File: rtl/rx_payload_gate.sv
module rx_payload_gate #(
  parameter int LEN_W     = 12,
  parameter int HDR_BYTES = 8,
  localparam int XW       = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [XW-1:0]    total_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_last_o,
  output logic             done_o
);
  logic             active_q;
  logic [XW-1:0]    idx_q, total_q, off;
  logic [LEN_W-1:0] len_q;
  logic             fwd, last;

  assign off  = idx_q - XW'(HDR_BYTES);
  assign fwd  = (idx_q >= XW'(HDR_BYTES)) && (off < {1'b0, len_q});
  assign last = (off == ({1'b0, len_q} - XW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      idx_q       <= '0;
      total_q     <= '0;
      len_q       <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      done_o      <= 1'b0;
      if (arm_i) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        len_q    <= len_i;
        total_q  <= total_i;
      end else if (active_q && byte_valid_i) begin
        idx_q       <= idx_q + XW'(1);
        out_valid_o <= fwd;
        out_last_o  <= fwd && last;
        out_data_o  <= byte_i;
        if (idx_q == total_q - XW'(1)) begin
          active_q <= 1'b0;
          done_o   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_drop_counters.sv
module rx_drop_counters #(
  parameter int N     = 3,
  parameter int CNT_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N-1:0]             inc_i,
  output logic [N-1:0][CNT_W-1:0]  cnt_o
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           cnt_o[g] <= '0;
      else if (inc_i[g] && (cnt_o[g] != '1)) cnt_o[g] <= cnt_o[g] + CNT_W'(1);
    end

    p_sat_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_o[g] == '1) |=> (cnt_o[g] == '1));
  end
endmodule

// File: rtl/rx_drain_seq.sv
module rx_drain_seq
  import rx_drain_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int MAX_XFER  = 1500,
  parameter int HDR_BYTES = 8,
  parameter int CNT_W     = 8,
  localparam int XW       = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_i,
  output logic             reg_req_o,
  output logic             reg_we_o,
  output logic [7:0]       reg_addr_o,
  output logic [15:0]      reg_wdata_o,
  input  logic             reg_ack_i,
  input  logic [15:0]      reg_rdata_i,
  output logic             bulk_start_o,
  output logic [XW-1:0]    bulk_bytes_o,
  input  logic             bulk_valid_i,
  input  logic [7:0]       bulk_data_i,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_last_o,
  output logic [LEN_W-1:0] out_len_o,
  output logic [CNT_W-1:0] drop_status_o,
  output logic [CNT_W-1:0] drop_zero_o,
  output logic [CNT_W-1:0] drop_long_o
);
  state_e           state_q;
  cmd_op_e          op_q;
  logic [7:0]       frames_q;
  logic [15:0]      status_q, shadow_q;
  logic [LEN_W-1:0] len_q;
  logic [N_REASON-1:0] reason, drop_inc;
  logic [XW-1:0]    pad;
  logic             gate_done;
  logic [N_REASON-1:0][CNT_W-1:0] cnt;

  rx_frame_judge #(.LEN_W(LEN_W), .MAX_XFER(MAX_XFER)) u_judge (
    .status_i(status_q), .len_i(len_q), .reason_o(reason), .pad_o(pad)
  );

  assign bulk_start_o = (state_q == S_BULK);
  assign bulk_bytes_o = XW'(HDR_BYTES) + pad;
  assign out_len_o    = len_q;
  assign drop_inc     = (state_q == S_JUDGE) ? reason : '0;

  rx_payload_gate #(.LEN_W(LEN_W), .HDR_BYTES(HDR_BYTES)) u_gate (
    .clk_i, .rst_ni, .arm_i(bulk_start_o), .len_i(len_q), .total_i(bulk_bytes_o),
    .byte_valid_i(bulk_valid_i), .byte_i(bulk_data_i),
    .out_valid_o, .out_data_o, .out_last_o, .done_o(gate_done)
  );

  rx_drop_counters #(.N(N_REASON), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .inc_i(drop_inc), .cnt_o(cnt)
  );
  assign drop_status_o = cnt[0];
  assign drop_zero_o   = cnt[1];
  assign drop_long_o   = cnt[2];

  always_comb begin
    reg_req_o   = 1'b0;
    reg_we_o    = 1'b0;
    reg_addr_o  = '0;
    reg_wdata_o = '0;
    unique case (state_q)
      S_ISR:  begin reg_req_o = 1'b1; reg_addr_o = A_ISR; end
      S_ACK:  begin reg_req_o = 1'b1; reg_we_o = 1'b1; reg_addr_o = A_ISR;
                    reg_wdata_o = 16'(1) << B_RXIRQ; end
      S_CNT:  begin reg_req_o = 1'b1; reg_addr_o = A_FCNT; end
      S_STAT: begin reg_req_o = 1'b1; reg_addr_o = A_STAT; end
      S_LEN:  begin reg_req_o = 1'b1; reg_addr_o = A_BCNT; end
      S_PTR:  begin reg_req_o = 1'b1; reg_we_o = 1'b1; reg_addr_o = A_RPTR;
                    reg_wdata_o = 16'(1) << B_AINC; end
      S_CRD, S_POLL: begin reg_req_o = 1'b1; reg_addr_o = A_QCMD; end
      S_CWR: begin
        reg_req_o  = 1'b1;
        reg_we_o   = 1'b1;
        reg_addr_o = A_QCMD;
        unique case (op_q)
          OP_REL:    reg_wdata_o = shadow_q | (16'(1) << B_REL);
          OP_DMA_ON: reg_wdata_o = shadow_q | (16'(1) << B_DMA);
          default:   reg_wdata_o = shadow_q & ~(16'(1) << B_DMA);
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      op_q     <= OP_REL;
      frames_q <= '0;
      status_q <= '0;
      shadow_q <= '0;
      len_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (irq_i) state_q <= S_ISR;
        S_ISR:  if (reg_ack_i) state_q <= reg_rdata_i[B_RXIRQ] ? S_ACK : S_IDLE;
        S_ACK:  if (reg_ack_i) state_q <= S_CNT;
        S_CNT:  if (reg_ack_i) begin
          frames_q <= reg_rdata_i[15:8];
          state_q  <= (reg_rdata_i[15:8] == '0) ? S_IDLE : S_STAT;
        end
        S_STAT: if (reg_ack_i) begin status_q <= reg_rdata_i; state_q <= S_LEN; end
        S_LEN:  if (reg_ack_i) begin len_q <= reg_rdata_i[LEN_W-1:0]; state_q <= S_JUDGE; end
        S_JUDGE: begin
          op_q    <= OP_REL;
          state_q <= (reason == '0) ? S_PTR : S_CRD;
        end
        S_PTR:  if (reg_ack_i) begin op_q <= OP_DMA_ON; state_q <= S_CRD; end
        S_CRD:  if (reg_ack_i) begin shadow_q <= reg_rdata_i; state_q <= S_CWR; end
        S_CWR:  if (reg_ack_i) begin
          unique case (op_q)
            OP_REL:    state_q <= S_POLL;
            OP_DMA_ON: state_q <= S_BULK;
            default:   state_q <= S_NEXT;
          endcase
        end
        S_POLL:  if (reg_ack_i && !reg_rdata_i[B_REL]) state_q <= S_NEXT;
        S_BULK:  state_q <= S_BWAIT;
        S_BWAIT: if (gate_done) begin op_q <= OP_DMA_OFF; state_q <= S_CRD; end
        S_NEXT: begin
          frames_q <= frames_q - 8'd1;
          state_q  <= (frames_q == 8'd1) ? S_IDLE : S_STAT;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_o && !reg_ack_i) |=> (reg_req_o && $stable(reg_addr_o) &&
                                   $stable(reg_we_o) && $stable(reg_wdata_o)));
  p_bulk_aligned_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bulk_start_o |-> (bulk_bytes_o[1:0] == 2'b00 && bulk_bytes_o <= XW'(MAX_XFER + HDR_BYTES)));
  p_stream_in_bulk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (state_q == S_BWAIT));
  p_frames_left_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_STAT) |-> (frames_q != '0));
endmodule

// File: tb/sim_rx_drain_seq.sv
module sim_rx_drain_seq;
  localparam int LEN_W = 12;
  localparam int CNT_W = 3;
  localparam int XW    = LEN_W + 1;
  localparam int SAT   = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_ni = 1'b0, irq_i = 1'b0;
  logic reg_req_o, reg_we_o, reg_ack_i = 1'b0;
  logic [7:0] reg_addr_o;
  logic [15:0] reg_wdata_o, reg_rdata_i = '0;
  logic bulk_start_o, bulk_valid_i = 1'b0;
  logic [XW-1:0] bulk_bytes_o;
  logic [7:0] bulk_data_i = '0;
  logic out_valid_o, out_last_o;
  logic [7:0] out_data_o;
  logic [LEN_W-1:0] out_len_o;
  logic [CNT_W-1:0] drop_status_o, drop_zero_o, drop_long_o;

  rx_drain_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u0 (.clk_i(clk), .*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  logic [15:0] fs[32];
  logic [11:0] fl[32];
  bit facc[32];
  int nfr = 0, rd_idx = 0, cur = 0, consumed = 0, pend = 0, rel_cnt = 0, isr_reads = 0;
  int exp_st = 0, exp_z = 0, exp_l = 0;
  bit isr_m = 0, force_m = 0, acked = 0, ptr_ok = 0, bulk_done = 0, rel_pend = 0;
  logic [15:0] cmd_reg = 16'h0100;
  logic [20:0] sb[$];

  function automatic int padded(input int l);
    return (l + 3) / 4 * 4;
  endfunction
  function automatic logic [7:0] pbyte(input int f, input int i);
    return 8'(f * 37 + i * 3 + 1);
  endfunction

  task automatic load(input logic [15:0] s, input int l);
    bit bad;
    bad = !s[15] || ((s & 16'h3C17) != 0);
    fs[nfr] = s; fl[nfr] = 12'(l); facc[nfr] = 0;
    if (bad) exp_st++;
    else if (l == 0) exp_z++;
    else if (padded(l) > 1500) exp_l++;
    else begin
      facc[nfr] = 1;
      for (int i = 0; i < l; i++) sb.push_back({(i == l - 1), 12'(l), pbyte(nfr, i)});
    end
    nfr++;
  endtask

  task automatic fire(input int n);
    pend = n;
    isr_m = 1;
    wait (consumed == nfr);
    repeat (40) @(negedge clk);
    chk(!reg_req_o && !irq_i, "R11 idle after burst", reg_req_o, 0);
  endtask

  task automatic serve();
    case (reg_addr_o)
      8'h92: if (reg_we_o) begin
        chk(reg_wdata_o == 16'h2000 && isr_m, "R2 ack write", reg_wdata_o, 16'h2000);
        isr_m = 0; acked = 1;
      end else begin
        reg_rdata_i = {2'b00, isr_m, 13'h0};
        isr_reads++;
      end
      8'h9C: begin
        chk(!reg_we_o && acked, "R2 count after ack", acked, 1);
        acked = 0;
        reg_rdata_i = {8'(pend), 8'h5A};
        pend = 0;
      end
      8'h7C: begin
        chk(!rel_pend, "R7 release done before next frame", rel_pend, 0);
        chk(!cmd_reg[3], "R8 dma bit cleared before next frame", cmd_reg[3], 0);
        chk(rd_idx < nfr, "R11 status read within count", rd_idx, nfr);
        if (rd_idx < nfr) begin cur = rd_idx; rd_idx++; end
        reg_rdata_i = fs[cur];
      end
      8'h7E: reg_rdata_i = {4'hF, fl[cur]};
      8'h86: begin
        chk(reg_we_o && reg_wdata_o == 16'h4000 && facc[cur], "R8 pointer write", reg_wdata_o, 16'h4000);
        ptr_ok = 1;
      end
      8'h82: if (!reg_we_o) begin
        reg_rdata_i = {cmd_reg[15:1], rel_cnt != 0};
        if (rel_cnt != 0) rel_cnt--;
        else if (rel_pend) begin rel_pend = 0; consumed++; end
      end else begin
        chk(reg_wdata_o[8], "R7 other command bits kept", reg_wdata_o, 16'h0100);
        if (reg_wdata_o[0]) begin
          chk(!facc[cur] && !cmd_reg[3], "R4 release only for bad frame", cur, 0);
          rel_cnt = 2; rel_pend = 1;
          cmd_reg = reg_wdata_o & ~16'h0001;
        end else if (reg_wdata_o[3] && !cmd_reg[3]) begin
          chk(facc[cur] && ptr_ok, "R8 dma start on good frame", facc[cur], 1);
          cmd_reg = reg_wdata_o; bulk_done = 0;
        end else if (!reg_wdata_o[3] && cmd_reg[3]) begin
          chk(bulk_done, "R8 dma stop after bulk", bulk_done, 1);
          cmd_reg = reg_wdata_o; ptr_ok = 0; consumed++;
        end else chk(0, "R8 stray command write", reg_wdata_o, cmd_reg);
      end
      default: chk(0, "R2 unknown address", reg_addr_o, 0);
    endcase
  endtask

  initial forever begin
    @(negedge clk);
    irq_i = isr_m || force_m;
    if (reg_ack_i) reg_ack_i = 0;
    else if (reg_req_o && rst_ni) begin reg_ack_i = 1; serve(); end
  end

  initial forever begin
    @(negedge clk);
    if (bulk_start_o) begin
      automatic int tot = 8 + padded(fl[cur]);
      chk(cmd_reg[3] && ptr_ok, "R8 bulk after setup", cmd_reg[3], 1);
      chk(bulk_bytes_o == XW'(tot), "R8 bulk byte count", bulk_bytes_o, tot);
      @(negedge clk);
      for (int i = 0; i < tot; i++) begin
        if (i % 7 == 3) begin bulk_valid_i = 0; @(negedge clk); end
        bulk_valid_i = 1;
        bulk_data_i = (i < 8) ? 8'hEE : ((i - 8 < fl[cur]) ? pbyte(cur, i - 8) : 8'hA5);
        @(negedge clk);
      end
      bulk_valid_i = 0;
      bulk_done = 1;
    end
  end

  initial forever begin
    @(negedge clk);
    if (out_valid_o) begin
      if (sb.size() == 0) chk(0, "R9 unexpected byte", out_data_o, 0);
      else begin
        automatic logic [20:0] e = sb.pop_front();
        chk(out_data_o == e[7:0], "R9 payload byte", out_data_o, e[7:0]);
        chk(out_last_o == e[20], "R9 last flag", out_last_o, e[20]);
        chk(out_len_o == e[19:8], "R9 length tag", out_len_o, e[19:8]);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(!reg_req_o && !bulk_start_o && !out_valid_o, "R1 outputs idle", reg_req_o, 0);
    chk(drop_status_o == 0 && drop_zero_o == 0 && drop_long_o == 0, "R1 counters zero",
        drop_status_o, 0);
    force_m = 1;
    repeat (30) @(negedge clk);
    force_m = 0;
    repeat (10) @(negedge clk);
    chk(isr_reads > 0 && !reg_req_o, "R2 spurious line gives reads only", isr_reads, 1);
    fire(0);  // R11 zero count
    load(16'h8000, 60); load(16'h8020, 1); load(16'h8000, 61);
    fire(3);
    load(16'h0000, 64);   // R4 no valid bit
    load(16'h8400, 64);   // R4 error bit 10
    load(16'h8000, 0);    // R5
    load(16'h8000, 1497); // R6 pads to 1500
    load(16'h8000, 1501); // R6 pads past limit
    load(16'h8000, 1500);
    load(16'h8008, 5);    // R4 bit 3 ignored
    load(16'h8001, 0);    // R10 status wins over zero length
    fire(8);
    load(16'h8002, 8); load(16'h8004, 8); load(16'h8010, 8);
    load(16'h9000, 8); load(16'hA000, 8); load(16'h8800, 8); load(16'h8000, 3);
    fire(7);
    chk(drop_status_o == CNT_W'((exp_st > SAT) ? SAT : exp_st), "R10 status drops saturate",
        drop_status_o, (exp_st > SAT) ? SAT : exp_st);
    chk(drop_zero_o == CNT_W'(exp_z), "R5 zero-length drops", drop_zero_o, exp_z);
    chk(drop_long_o == CNT_W'(exp_l), "R6 oversize drops", drop_long_o, exp_l);
    chk(sb.size() == 0, "R9 all payload delivered", sb.size(), 0);
    chk(rd_idx == nfr, "R3 every frame read once", rd_idx, nfr);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R11 watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule